// File: doc/BRIEF.md
# DMA Channel Event Flag Unit

This block keeps the status events of a single DMA channel and raises its interrupt request. It sits next to the channel's data movement engine and watches that engine's signals: the transfer counter as it counts down, the trigger pulses, the channel enable, the busy indication, and the source and destination addresses of every access. From these it keeps sticky flags for the half-way point, completion, overrun, and violations of the upper and lower address limits. It also selects the channel's trigger from a vector of trigger inputs, and it keeps a pending flag for the buffered data of the null-write mode.

Software sees one 16-bit control and flag register through a simple write strobe and a read bus. The register holds the trigger select field, the half-way interrupt enable and the flags. Hardware events set flags and pulse the interrupt output. Software writes can set or clear flags, but they never produce an interrupt. Address limit violations are detected on the access itself. The access still goes ahead, and the flag appears afterwards.

Top module: `dma_evt_unit`

## Requirements
- R1: After reset, every register bit reads 0 and `irq` is 0.
- R2: Register bits [5:0] hold the trigger select. Bit 6 holds the half-way interrupt enable. Both are written by `reg_wr` and read back on `reg_rdata`. `trig_go` equals `ch_en` AND `trig_vec[select]`, in the same cycle.
- R3: When `trig_go` and `busy` are both 1 in a cycle, the overrun flag (bit 8) reads 1 from the next cycle on.
- R4: When `cnt_dec` is 1 and `cnt_cur` equals `cnt_start` divided by two (rounded down), the half-way flag (bit 9) reads 1 from the next cycle on.
- R5: When `cnt_dec` is 1 and `cnt_cur` is 0, the done flag (bit 10) is set. A rising edge of `ch_en` clears the done flag, unless a completion happens in the same cycle. A session that is stopped before completion therefore leaves the flag at 0.
- R6: When `acc_vld` is 1 and either address is above `lim_hi` or above the RAM top parameter (default 0x5FFF), the high-limit flag (bit 12) is set.
- R7: When `acc_vld` is 1 and either address is below `lim_lo` but above 0x07FF, the low-limit flag (bit 11) is set. Addresses at or below 0x07FF never set it.
- R8: `irq` is a one-cycle pulse in the cycle after a hardware overrun, completion, high-limit or low-limit event. A half-way event pulses it only while bit 6 is 1.
- R9: A register write loads bits 8 to 12 from the write data. Writing 1 sets a flag, writing 0 clears it, and neither raises `irq`. A hardware set in the same cycle wins over a software clear.
- R10: The buffer-pending flag (bit 13) is set by `buf_load` while `nw_mode` is 1 and cleared by `buf_wr`. A set wins when both happen together. Register writes do not change it. Bits 7, 14 and 15 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data |
| trig_vec | input | 64 | Trigger inputs |
| trig_go | output | 1 | Selected trigger, qualified by the enable |
| ch_en | input | 1 | Channel enable |
| busy | input | 1 | Channel is still servicing the previous trigger |
| cnt_dec | input | 1 | Transfer counter has just decremented |
| cnt_cur | input | 16 | Counter value after the decrement |
| cnt_start | input | 16 | Counter value at the start of the session |
| acc_vld | input | 1 | An access took place this cycle |
| src_addr | input | 16 | Source address of the access |
| dst_addr | input | 16 | Destination address of the access |
| lim_lo | input | 16 | Programmed lower address limit |
| lim_hi | input | 16 | Programmed upper address limit |
| nw_mode | input | 1 | Null-write mode active |
| buf_load | input | 1 | Data captured into the channel buffer |
| buf_wr | input | 1 | Buffered data written to its target |
| irq | output | 1 | Interrupt request pulse |

## Verification
The hardest cases to reach are same-cycle collisions. One is a software clear of a flag in the very cycle a hardware event sets it. Another is a channel enable rising in the cycle the counter reaches zero. A third is a buffer load that coincides with the buffer write. Random stimulus rarely lines these up, so the bench drives each of them on purpose in a single cycle, right after a directed setup. It also drives addresses exactly at the 0x07FF boundary, the RAM top and each programmed limit. A long random phase then draws from those same edge values, and a behavioural model checks every cycle of it.

// File: rtl/dma_evt_pkg.sv
package dma_evt_pkg;
  localparam int REG_W  = 16;
  localparam int F_SEL  = 0;
  localparam int F_HEN  = 6;
  localparam int F_OVR  = 8;
  localparam int F_HALF = 9;
  localparam int F_DONE = 10;
  localparam int F_LOW  = 11;
  localparam int F_HIGH = 12;
  localparam int F_BUF  = 13;

  typedef struct packed {
    logic ovr;
    logic half;
    logic done;
    logic low;
    logic high;
  } evt_t;

  function automatic logic at_half(input int unsigned start, input int unsigned cur);
    return cur == (start >> 1);
  endfunction

  function automatic logic above_window(input int unsigned addr, input int unsigned lim,
                                        input int unsigned top);
    return (addr > lim) || (addr > top);
  endfunction

  function automatic logic in_low_gap(input int unsigned addr, input int unsigned lim,
                                      input int unsigned sfr_top);
    return (addr < lim) && (addr > sfr_top);
  endfunction
endpackage

// File: rtl/dma_trig_sel.sv
module dma_trig_sel #(
  parameter int NTRIG = 64,
  parameter int SEL_W = 6
) (
  input  logic [NTRIG-1:0] trig_vec,
  input  logic [SEL_W-1:0] sel,
  input  logic             ch_en,
  input  logic             busy,
  output logic             trig_go,
  output logic             evt_ovr
);
  localparam int NSLOT = 1 << SEL_W;
  logic [NSLOT-1:0] slots;

  generate
    if (NTRIG < NSLOT) begin : g_pad
      assign slots = {{(NSLOT-NTRIG){1'b0}}, trig_vec};
    end else begin : g_full
      assign slots = trig_vec[NSLOT-1:0];
    end
  endgenerate

  assign trig_go = ch_en & slots[sel];
  assign evt_ovr = trig_go & busy;
endmodule

// File: rtl/dma_evt_detect.sv
module dma_evt_detect
  import dma_evt_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int ADDR_W = 16,
  parameter int NPORT = 2,
  parameter logic [ADDR_W-1:0] RAM_TOP = 16'h5FFF,
  parameter logic [ADDR_W-1:0] SFR_TOP = 16'h07FF
) (
  input  logic                         cnt_dec,
  input  logic [CNT_W-1:0]             cnt_cur,
  input  logic [CNT_W-1:0]             cnt_start,
  input  logic                         acc_vld,
  input  logic [NPORT-1:0][ADDR_W-1:0] addrs,
  input  logic [ADDR_W-1:0]            lim_lo,
  input  logic [ADDR_W-1:0]            lim_hi,
  output logic                         evt_half,
  output logic                         evt_done,
  output logic                         evt_high,
  output logic                         evt_low
);
  logic [NPORT-1:0] hi_hit;
  logic [NPORT-1:0] lo_hit;

  generate
    for (genvar p = 0; p < NPORT; p++) begin : g_port
      assign hi_hit[p] = above_window(32'(addrs[p]), 32'(lim_hi), 32'(RAM_TOP));
      assign lo_hit[p] = in_low_gap(32'(addrs[p]), 32'(lim_lo), 32'(SFR_TOP));
    end
  endgenerate

  assign evt_half = cnt_dec & at_half(32'(cnt_start), 32'(cnt_cur));
  assign evt_done = cnt_dec & (cnt_cur == '0);
  assign evt_high = acc_vld & (|hi_hit);
  assign evt_low  = acc_vld & (|lo_hit);
endmodule

// File: rtl/dma_flag_bank.sv
module dma_flag_bank
  import dma_evt_pkg::*;
#(
  parameter int SEL_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  input  evt_t             evt,
  input  logic             ch_en,
  input  logic             buf_set,
  input  logic             buf_clr,
  output logic [SEL_W-1:0] sel,
  output logic             en_rise,
  output logic             evt_any,
  output logic [REG_W-1:0] reg_rdata,
  output logic             irq
);
  logic half_en;
  logic f_ovr, f_half, f_done, f_low, f_high, f_buf;
  logic en_q;

  assign en_rise = ch_en & ~en_q;
  assign evt_any = evt.ovr | evt.done | evt.high | evt.low | (evt.half & half_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel     <= '0;
      half_en <= 1'b0;
      f_ovr   <= 1'b0;
      f_half  <= 1'b0;
      f_done  <= 1'b0;
      f_low   <= 1'b0;
      f_high  <= 1'b0;
      f_buf   <= 1'b0;
      en_q    <= 1'b0;
      irq     <= 1'b0;
    end else begin
      en_q <= ch_en;
      irq  <= evt_any;
      if (reg_wr) begin
        sel     <= reg_wdata[F_SEL +: SEL_W];
        half_en <= reg_wdata[F_HEN];
      end
      f_ovr  <= evt.ovr  | (reg_wr ? reg_wdata[F_OVR]  : f_ovr);
      f_half <= evt.half | (reg_wr ? reg_wdata[F_HALF] : f_half);
      f_low  <= evt.low  | (reg_wr ? reg_wdata[F_LOW]  : f_low);
      f_high <= evt.high | (reg_wr ? reg_wdata[F_HIGH] : f_high);
      f_done <= evt.done | (en_rise ? 1'b0 : (reg_wr ? reg_wdata[F_DONE] : f_done));
      f_buf  <= buf_set  | (buf_clr ? 1'b0 : f_buf);
    end
  end

  always_comb begin
    reg_rdata                 = '0;
    reg_rdata[F_SEL +: SEL_W] = sel;
    reg_rdata[F_HEN]          = half_en;
    reg_rdata[F_OVR]          = f_ovr;
    reg_rdata[F_HALF]         = f_half;
    reg_rdata[F_DONE]         = f_done;
    reg_rdata[F_LOW]          = f_low;
    reg_rdata[F_HIGH]         = f_high;
    reg_rdata[F_BUF]          = f_buf;
  end
endmodule

// File: rtl/dma_evt_unit.sv
module dma_evt_unit
  import dma_evt_pkg::*;
#(
  parameter int NTRIG = 64,
  parameter int CNT_W = 16,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] RAM_TOP = 16'h5FFF,
  parameter logic [ADDR_W-1:0] SFR_TOP = 16'h07FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [NTRIG-1:0]  trig_vec,
  output logic              trig_go,
  input  logic              ch_en,
  input  logic              busy,
  input  logic              cnt_dec,
  input  logic [CNT_W-1:0]  cnt_cur,
  input  logic [CNT_W-1:0]  cnt_start,
  input  logic              acc_vld,
  input  logic [ADDR_W-1:0] src_addr,
  input  logic [ADDR_W-1:0] dst_addr,
  input  logic [ADDR_W-1:0] lim_lo,
  input  logic [ADDR_W-1:0] lim_hi,
  input  logic              nw_mode,
  input  logic              buf_load,
  input  logic              buf_wr,
  output logic              irq
);
  localparam int SEL_W = (NTRIG > 1) ? $clog2(NTRIG) : 1;
  localparam int NPORT = 2;

  logic [SEL_W-1:0]             sel;
  logic                         evt_ovr, evt_half, evt_done, evt_high, evt_low;
  logic                         evt_any;
  logic                         en_rise;
  logic                         buf_set;
  evt_t                         evt;
  logic [NPORT-1:0][ADDR_W-1:0] addrs;

  assign addrs   = {dst_addr, src_addr};
  assign buf_set = nw_mode & buf_load;
  assign evt     = '{ovr: evt_ovr, half: evt_half, done: evt_done, low: evt_low, high: evt_high};

  dma_trig_sel #(.NTRIG(NTRIG), .SEL_W(SEL_W)) u_trig (
    .trig_vec(trig_vec), .sel(sel), .ch_en(ch_en), .busy(busy),
    .trig_go(trig_go), .evt_ovr(evt_ovr)
  );

  dma_evt_detect #(
    .CNT_W(CNT_W), .ADDR_W(ADDR_W), .NPORT(NPORT), .RAM_TOP(RAM_TOP), .SFR_TOP(SFR_TOP)
  ) u_det (
    .cnt_dec(cnt_dec), .cnt_cur(cnt_cur), .cnt_start(cnt_start),
    .acc_vld(acc_vld), .addrs(addrs), .lim_lo(lim_lo), .lim_hi(lim_hi),
    .evt_half(evt_half), .evt_done(evt_done), .evt_high(evt_high), .evt_low(evt_low)
  );

  dma_flag_bank #(.SEL_W(SEL_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .evt(evt), .ch_en(ch_en), .buf_set(buf_set), .buf_clr(buf_wr),
    .sel(sel), .en_rise(en_rise), .evt_any(evt_any),
    .reg_rdata(reg_rdata), .irq(irq)
  );
endmodule

// File: rtl/dma_evt_chk.sv
module dma_evt_chk
  import dma_evt_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] RAM_TOP = 16'h5FFF,
  parameter logic [ADDR_W-1:0] SFR_TOP = 16'h07FF
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [REG_W-1:0]  reg_wdata,
  input logic [REG_W-1:0]  reg_rdata,
  input logic              trig_go,
  input logic              busy,
  input logic              ch_en,
  input logic              cnt_dec,
  input logic [CNT_W-1:0]  cnt_cur,
  input logic              acc_vld,
  input logic [ADDR_W-1:0] src_addr,
  input logic [ADDR_W-1:0] dst_addr,
  input logic              nw_mode,
  input logic              buf_load,
  input logic              buf_wr,
  input logic              evt_any,
  input logic              irq
);
  a_r3_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
    trig_go && busy |=> reg_rdata[F_OVR]);

  a_r5_rise_clears_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ch_en) && !(cnt_dec && cnt_cur == '0) |=> !reg_rdata[F_DONE]);

  a_r6_ram_top: assert property (@(posedge clk) disable iff (!rst_n)
    acc_vld && (src_addr > RAM_TOP) |=> reg_rdata[F_HIGH]);

  a_r7_sfr_exempt: assert property (@(posedge clk) disable iff (!rst_n)
    acc_vld && src_addr <= SFR_TOP && dst_addr <= SFR_TOP && !reg_rdata[F_LOW]
    && !(reg_wr && reg_wdata[F_LOW]) |=> !reg_rdata[F_LOW]);

  a_r8_irq_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(evt_any));

  a_r9_sw_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && !evt_any |=> !irq);

  a_r10_buf_sets: assert property (@(posedge clk) disable iff (!rst_n)
    nw_mode && buf_load |=> reg_rdata[F_BUF]);

  a_r10_buf_clears: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr && !(nw_mode && buf_load) |=> !reg_rdata[F_BUF]);
endmodule

bind dma_evt_unit dma_evt_chk #(
  .CNT_W(CNT_W), .ADDR_W(ADDR_W), .RAM_TOP(RAM_TOP), .SFR_TOP(SFR_TOP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .trig_go(trig_go), .busy(busy), .ch_en(ch_en), .cnt_dec(cnt_dec), .cnt_cur(cnt_cur),
  .acc_vld(acc_vld), .src_addr(src_addr), .dst_addr(dst_addr), .nw_mode(nw_mode),
  .buf_load(buf_load), .buf_wr(buf_wr), .evt_any(evt_any), .irq(irq)
);

// File: tb/tb_dma_evt_unit.sv
module tb_dma_evt_unit;
  localparam int CLK_P = 10;
  localparam int RAMTOP = 'h5FFF;
  localparam int SFRTOP = 'h07FF;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_wr = 0;
  logic [15:0] reg_wdata = 0;
  logic [15:0] reg_rdata;
  logic [63:0] trig_vec = 0;
  logic        trig_go;
  logic        ch_en = 0, busy = 0, cnt_dec = 0, acc_vld = 0;
  logic [15:0] cnt_cur = 0, cnt_start = 0, src_addr = 0, dst_addr = 0;
  logic [15:0] lim_lo = 16'h1000, lim_hi = 16'h4000;
  logic        nw_mode = 0, buf_load = 0, buf_wr = 0;
  logic        irq;

  int vectors = 0;
  int fails = 0;

  // reference state
  int m_sel = 0;
  bit m_hen, m_ovr, m_half, m_done, m_low, m_high, m_buf, m_irq, m_enq;

  always #(CLK_P/2) clk = ~clk;

  dma_evt_unit dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .trig_vec(trig_vec), .trig_go(trig_go), .ch_en(ch_en), .busy(busy),
    .cnt_dec(cnt_dec), .cnt_cur(cnt_cur), .cnt_start(cnt_start),
    .acc_vld(acc_vld), .src_addr(src_addr), .dst_addr(dst_addr),
    .lim_lo(lim_lo), .lim_hi(lim_hi), .nw_mode(nw_mode), .buf_load(buf_load),
    .buf_wr(buf_wr), .irq(irq)
  );

  function automatic bit hi_bad(int a);
    return a > int'(lim_hi) || a > RAMTOP;
  endfunction
  function automatic bit lo_bad(int a);
    return a < int'(lim_lo) && a >= SFRTOP + 1;
  endfunction

  always @(posedge clk) begin
    bit go, e_ovr, e_half, e_done, e_hi, e_lo;
    if (!rst_n) begin
      m_sel = 0; m_hen = 0; m_ovr = 0; m_half = 0; m_done = 0;
      m_low = 0; m_high = 0; m_buf = 0; m_irq = 0; m_enq = 0;
    end else begin
      go     = ch_en && trig_vec[m_sel];
      e_ovr  = go && busy;
      e_half = cnt_dec && (int'(cnt_cur) * 2 == int'(cnt_start)
                           || int'(cnt_cur) * 2 + 1 == int'(cnt_start));
      e_done = cnt_dec && cnt_cur == 0;
      e_hi   = acc_vld && (hi_bad(int'(src_addr)) || hi_bad(int'(dst_addr)));
      e_lo   = acc_vld && (lo_bad(int'(src_addr)) || lo_bad(int'(dst_addr)));
      m_irq  = e_ovr || e_done || e_hi || e_lo || (e_half && m_hen);
      if (reg_wr) begin
        m_sel = int'(reg_wdata[5:0]); m_hen = reg_wdata[6];
        m_ovr = reg_wdata[8]; m_half = reg_wdata[9]; m_done = reg_wdata[10];
        m_low = reg_wdata[11]; m_high = reg_wdata[12];
      end
      if (ch_en && !m_enq) m_done = 0;
      if (e_ovr) m_ovr = 1;
      if (e_half) m_half = 1;
      if (e_done) m_done = 1;
      if (e_hi) m_high = 1;
      if (e_lo) m_low = 1;
      if (buf_wr) m_buf = 0;
      if (nw_mode && buf_load) m_buf = 1;
      m_enq = ch_en;
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk(reg_rdata[5:0] == 6'(m_sel) && reg_rdata[6] == m_hen, "R2 select/enable",
        int'(reg_rdata[6:0]), {m_hen, 6'(m_sel)});
    chk(trig_go == (ch_en && trig_vec[m_sel]), "R2 trig_go", trig_go, ch_en && trig_vec[m_sel]);
    chk(reg_rdata[8] == m_ovr, "R3 overrun", reg_rdata[8], m_ovr);
    chk(reg_rdata[9] == m_half, "R4 half", reg_rdata[9], m_half);
    chk(reg_rdata[10] == m_done, "R5 done", reg_rdata[10], m_done);
    chk(reg_rdata[12] == m_high, "R6 high", reg_rdata[12], m_high);
    chk(reg_rdata[11] == m_low, "R7 low", reg_rdata[11], m_low);
    chk(irq == m_irq, "R8 irq", irq, m_irq);
    chk(reg_rdata[13] == m_buf && reg_rdata[7] == 0 && reg_rdata[15:14] == 0, "R10 buf/spare",
        int'(reg_rdata), int'(m_buf) << 13);
  endtask

  task automatic tick();
    @(posedge clk);
    #(CLK_P/4);
    compare_all();
  endtask

  task automatic quiet();
    reg_wr = 0; cnt_dec = 0; acc_vld = 0; buf_load = 0; buf_wr = 0; trig_vec = 0;
  endtask

  task automatic wr(logic [15:0] d);
    reg_wr = 1; reg_wdata = d; tick(); reg_wr = 0;
  endtask

  initial begin
    #(CLK_P * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #(CLK_P/4);
    chk(reg_rdata == 0 && irq == 0, "R1 reset state", int'(reg_rdata), 0);
    rst_n = 1;
    tick();
    chk(reg_rdata == 0 && irq == 0, "R1 after release", int'(reg_rdata), 0);

    // R2 / R3: select trigger 5, half enable on
    wr(16'h0045);
    ch_en = 1; tick();
    trig_vec[5] = 1; #1;
    chk(trig_go == 1, "R2 selected trigger", trig_go, 1);
    tick();
    busy = 1; tick(); trig_vec = 0; busy = 0;
    tick();
    chk(reg_rdata[8] == 1, "R3 overrun flag", reg_rdata[8], 1);
    trig_vec[6] = 1; busy = 1; tick(); trig_vec = 0; busy = 0;

    // R4 / R5 countdown 10 -> 0
    cnt_start = 10;
    for (int c = 9; c >= 0; c--) begin
      cnt_dec = 1; cnt_cur = 16'(c); tick();
    end
    cnt_dec = 0; tick();
    chk(reg_rdata[10:9] == 2'b11, "R5 done after countdown", reg_rdata[10:9], 3);

    // R8: half with half_en 0 sets the flag but no irq
    wr(16'h0005);
    cnt_start = 7; cnt_dec = 1; cnt_cur = 3; tick(); cnt_dec = 0;
    chk(irq == 0 && reg_rdata[9] == 1, "R8 half without enable", irq, 0);

    // R9: software set no irq, clear, collision
    wr(16'h1F05); tick();
    chk(irq == 0 && reg_rdata[12:8] == 5'h1F, "R9 sw set quiet", irq, 0);
    wr(16'h0005);
    chk(reg_rdata[12:8] == 0, "R9 sw clear", reg_rdata[12:8], 0);
    trig_vec[5] = 1; busy = 1; wr(16'h0005); trig_vec = 0; busy = 0;
    chk(reg_rdata[8] == 1, "R9 hw wins over clear", reg_rdata[8], 1);

    // R6 / R7 address windows
    acc_vld = 1;
    src_addr = 16'h4001; dst_addr = 16'h2000; tick();
    wr(16'h0005); acc_vld = 1;
    src_addr = 16'h2000; dst_addr = 16'h6000; lim_hi = 16'hFFFF; tick();
    wr(16'h0005); acc_vld = 1; lim_hi = 16'h4000;
    src_addr = 16'h07FF; dst_addr = 16'h0400; tick();
    chk(reg_rdata[11] == 0, "R7 register space exempt", reg_rdata[11], 0);
    src_addr = 16'h0800; dst_addr = 16'h1000; tick();
    chk(reg_rdata[11] == 1, "R7 gap hit", reg_rdata[11], 1);
    acc_vld = 0;

    // R5 session stopped early, then enable rise colliding with completion
    ch_en = 0; tick(); ch_en = 1; tick();
    chk(reg_rdata[10] == 0, "R5 rise clears done", reg_rdata[10], 0);
    ch_en = 0; tick(); tick();
    chk(reg_rdata[10] == 0, "R5 stopped early", reg_rdata[10], 0);
    ch_en = 1; cnt_dec = 1; cnt_cur = 0; tick(); cnt_dec = 0; tick();
    chk(reg_rdata[10] == 1, "R5 completion wins over rise", reg_rdata[10], 1);

    // R10 buffer pending
    buf_load = 1; tick(); buf_load = 0;
    nw_mode = 1; buf_load = 1; tick(); buf_load = 0;
    wr(16'h0005);
    chk(reg_rdata[13] == 1, "R10 write leaves buf", reg_rdata[13], 1);
    buf_wr = 1; buf_load = 1; tick(); buf_load = 0; tick(); buf_wr = 0; tick();
    chk(reg_rdata[13] == 0, "R10 buf cleared", reg_rdata[13], 0);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      int r;
      quiet();
      r = int'($urandom_range(0, 99));
      ch_en = (r < 90) ? ch_en : ~ch_en;
      busy = $urandom_range(0, 1) == 1;
      nw_mode = $urandom_range(0, 3) != 0;
      trig_vec[$urandom_range(0, 63)] = $urandom_range(0, 1) == 1;
      trig_vec[m_sel] = $urandom_range(0, 3) == 0;
      if ($urandom_range(0, 7) == 0) begin
        reg_wr = 1; reg_wdata = 16'($urandom);
      end
      cnt_dec = $urandom_range(0, 2) == 0;
      cnt_start = 16'($urandom_range(0, 20));
      cnt_cur = 16'($urandom_range(0, 10));
      acc_vld = $urandom_range(0, 1) == 1;
      case ($urandom_range(0, 5))
        0: src_addr = 16'h07FF;
        1: src_addr = 16'h0800;
        2: src_addr = lim_hi + 16'($urandom_range(0, 1));
        3: src_addr = lim_lo - 16'($urandom_range(0, 1));
        4: src_addr = 16'(RAMTOP + $urandom_range(0, 1));
        default: src_addr = 16'($urandom);
      endcase
      dst_addr = 16'($urandom_range(0, 16'h7FFF));
      buf_load = $urandom_range(0, 3) == 0;
      buf_wr = $urandom_range(0, 3) == 0;
      tick();
    end
    quiet();
    tick();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule